// File: doc/BRIEF.md
# Edge-Counting Reloadable Down Timer

This block counts falling edges on an asynchronous external pulse line instead of system clocks. Each edge is brought into the clock domain and then lowers a down counter by one. The counter is written in two byte-wide halves. Writing the upper half loads the whole value, clears any pending interrupt and arms the zero detector. The first time the counter steps from one to zero after a load, an interrupt flag is raised. The counter then keeps stepping down, wrapping past zero, so that software can still follow the position within a serial frame. It can do this until it writes a new count, for example a first count that lands on the last data bit and a second count for the trailing framing bits.

Software reads the live count through the same register port at any time. The status register reports the flag, and a write-one-to-clear on that register acknowledges it without reloading the counter. The interrupt output follows the flag.

Top module: `pulse_down_timer`

## Requirements
- R1: After synchronous reset the count reads 0, the status flag reads 0 and `irq` is low.
- R2: Each falling edge of `pulse_in` lowers the count by exactly one. Rising edges and a steady level leave the count unchanged.
- R3: A falling edge of `pulse_in` reaches the counter through a synchronizer of SYNC_STAGES flops (default 2) and an edge detector. The new count is in the counter by the third rising clock edge after the fall.
- R4: A write to address 0 only stages the low half and leaves the live count unchanged. A write to address 1 loads {written high half, staged low half} into the counter.
- R5: A load (write to address 1) clears the flag and `irq`, and re-arms zero detection.
- R6: When an armed counter steps from 1 to 0, the flag (status bit 0, address 2) and `irq` go high.
- R7: Once the flag is set, further edges keep lowering the count, wrapping from 0 to all ones. A later pass through zero does not set the flag again until the next load.
- R8: A write to address 2 with bit 0 set clears the flag without touching the count. A write to address 2 with bit 0 clear has no effect.
- R9: If a load and an edge-driven decrement fall in the same clock cycle, the load wins and the count equals the written value.
- R10: `bus_rdata` is registered and shows, one clock after `bus_addr` is applied: the count low half at address 0, the count high half at address 1, the flag in bit 0 at address 2 with the other bits zero, and zero at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous external pulse line, idle high |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, high while the flag is set |

## Verification
The hardest case to reach is a reload that lands in the same clock cycle as an edge-driven decrement. The bench reaches it by lowering `pulse_in` at a known falling clock edge and counting the synchronizer and detector stages. It then places the upper-half write strobe exactly on the edge where the decrement would take effect. The refusal to raise the flag a second time is reached by running a reduced-width instance through a full wrap of the counter after the flag has been acknowledged.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam int STATUS_FLAG_BIT = 0;
endpackage

// File: rtl/pdt_edge_sync.sv
module pdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // first stage takes the raw line; later stages chain
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b1;
    else     sync_q[0] <= din;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b1;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[LAST];
  end

  assign fall = last_q & ~sync_q[LAST];
endmodule

// File: rtl/pdt_count_core.sv
module pdt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ack_stb,
  input  logic             fall,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed_q;
  logic hit_zero;

  assign hit_zero = fall && armed_q && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (load_stb) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (fall) cnt_q <= cnt_q - ONE;
      if (hit_zero) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (ack_stb) begin
        flag_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdt_regport.sv
module pdt_regport
  import pdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [2*DATA_W-1:0] cnt,
  input  logic                flag,
  output logic                load_stb,
  output logic [2*DATA_W-1:0] load_val,
  output logic                ack_stb,
  output logic [DATA_W-1:0]   bus_rdata
);
  logic [DATA_W-1:0] lo_stage_q;
  logic [DATA_W-1:0] rd_next;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(bus_addr);
  assign load_stb = bus_wr && (sel == SEL_CNT_HI);
  assign load_val = {bus_wdata, lo_stage_q};
  assign ack_stb  = bus_wr && (sel == SEL_STATUS) && bus_wdata[STATUS_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst)                                lo_stage_q <= '0;
    else if (bus_wr && sel == SEL_CNT_LO)   lo_stage_q <= bus_wdata;
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_CNT_LO: rd_next = cnt[DATA_W-1:0];
      SEL_CNT_HI: rd_next = cnt[2*DATA_W-1:DATA_W];
      SEL_STATUS: rd_next[STATUS_FLAG_BIT] = flag;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/pulse_down_timer.sv
module pulse_down_timer #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_in,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic             fall_stb;
  logic             load_stb;
  logic             ack_stb;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  pdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pulse_in),
    .fall (fall_stb)
  );

  pdt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb),
    .load_val (load_val),
    .ack_stb  (ack_stb),
    .fall     (fall_stb),
    .cnt_q    (cnt_q),
    .flag_q   (flag_q)
  );

  pdt_regport #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .flag      (flag_q),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .ack_stb   (ack_stb),
    .bus_rdata (bus_rdata)
  );

  assign irq = flag_q;
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fall_stb,
  input logic             load_stb,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt_q == '0 && !irq));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !fall_stb) |=> (cnt_q == $past(cnt_q)));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && fall_stb) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // load also wins over a coincident edge (R9)
  assert_load_value_R4: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (cnt_q == $past(load_val)));

  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !irq);

  assert_zero_hit_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (cnt_q == '0 && $past(cnt_q) == CNT_W'(1)));
endmodule

bind pulse_down_timer pdt_checker #(.CNT_W(CNT_W)) u_pdt_checker (
  .clk      (clk),
  .rst      (rst),
  .fall_stb (fall_stb),
  .load_stb (load_stb),
  .load_val (load_val),
  .cnt_q    (cnt_q),
  .irq      (irq)
);

// File: tb/tb_pulse_down_timer.sv
module tb_pulse_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int CW = 2 * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pulse_in = 1'b1;
  logic [1:0]    bus_addr = 2'd0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_down_timer #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic rd_count(output int v);
    int lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = (hi << DW) | lo;
  endtask

  task automatic load(input int val);
    wr(2'd0, DW'(val));
    wr(2'd1, DW'(val >> DW));
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_in = 1'b0;
      repeat (3) @(negedge clk);
      pulse_in = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    rd_count(v);      check("R1 count", v, 0);
    rd(2'd2, v);      check("R1 status", v, 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_staging();
    int v;
    wr(2'd0, DW'(9));
    rd_count(v);      check("R4 low write alone", v, 0);
    wr(2'd1, DW'(0));
    rd_count(v);      check("R4 load", v, 9);
    check("R5 irq after load", int'(irq), 0);
  endtask

  task automatic t_count_and_hit();
    int v;
    pulses(8);
    rd_count(v);      check("R2 eight edges", v, 1);
    check("R6 irq before zero", int'(irq), 0);
    pulse_in = 1'b1; repeat (10) @(negedge clk);
    rd_count(v);      check("R2 steady level", v, 1);
    pulses(1);
    rd_count(v);      check("R6 count zero", v, 0);
    check("R6 irq", int'(irq), 1);
    rd(2'd2, v);      check("R6 status", v, 1);
    pulses(2);
    rd_count(v);      check("R7 wrap", v, (1 << CW) - 2);
    check("R7 irq held", int'(irq), 1);
  endtask

  task automatic t_ack();
    int v;
    wr(2'd2, DW'(0));
    check("R8 write zero ignored", int'(irq), 1);
    wr(2'd2, DW'(1));
    check("R8 ack clears", int'(irq), 0);
    rd_count(v);      check("R8 count untouched", v, (1 << CW) - 2);
  endtask

  task automatic t_split();
    int v;
    load(8);
    pulses(8);
    check("R6 first part", int'(irq), 1);
    load(3);
    check("R5 reload clears", int'(irq), 0);
    pulses(3);
    rd_count(v);      check("R6 second part count", v, 0);
    check("R6 second part irq", int'(irq), 1);
  endtask

  task automatic t_no_refire();
    int v;
    load(1);
    pulses(1);
    check("R7 armed hit", int'(irq), 1);
    wr(2'd2, DW'(1));
    pulses(1 << CW);
    rd_count(v);      check("R7 full wrap count", v, 0);
    check("R7 no refire", int'(irq), 0);
  endtask

  task automatic t_coincide();
    int v;
    wr(2'd0, DW'(7));
    @(negedge clk); pulse_in = 1'b0;   // fall seen at the next edge (stage 1)
    @(negedge clk);                    // stage 2 after next edge
    @(negedge clk);                    // decrement due at the following edge
    bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = DW'(0);
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    pulse_in = 1'b1;
    repeat (3) @(negedge clk);
    rd_count(v);      check("R9 load wins", v, 7);
    pulses(1);
    rd_count(v);      check("R3 next edge", v, 6);
  endtask

  task automatic t_latency();
    int v;
    bus_addr = 2'd0;
    @(negedge clk); pulse_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 not yet", int'(bus_rdata), 6);
    @(negedge clk);
    @(negedge clk);
    check("R3 after three edges", int'(bus_rdata), 5);
    pulse_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd3, v);      check("R10 spare addr", v, 0);
    rd(2'd2, v);      check("R10 status bits", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_staging();
    t_count_and_hit();
    t_ack();
    t_split();
    t_no_refire();
    t_coincide();
    t_latency();
    finish_run();
  end
endmodule